// File: doc/BRIEF.md
# Serial Wakeup Event Selector

This block sits beside a serial receiver and decides when a received-side event should wake the system from a low-power sleep state. The receiver supplies three things: a strobe when a start bit is detected, a strobe when a byte lands in the receive buffer, and the byte itself. A two-bit mode field picks one of these as the wakeup trigger:

- a received byte that matches a configured value,
- a start bit,
- the buffer becoming non-empty.

One mode code is reserved and never triggers.

The trigger is honoured only while the sleep input is asserted. It sets a sticky wakeup flag, and that flag stays set until an explicit clear strobe. An interrupt output reflects the flag, gated by an enable bit. The block also holds the configuration register. A mode write is dropped while the port enable input is high, so the trigger cannot change under a running port.

Top module: `serial_wake_sel`

## Requirements
- R1: After reset, `wake_flag_o`, `wake_irq_o` and `cfg_mode_o` are 0. The match value, the match-width select and the interrupt enable are also 0.
- R2: In mode 2'b00 with `cfg_nib_i`=0, a cycle with `sleep_i`=1 and `rx_valid_i`=1 sets the flag when all 8 bits of `rx_data_i` equal the configured value. A mismatching byte leaves the flag clear.
- R3: In mode 2'b00 with `cfg_nib_i`=1, the compare uses only `rx_data_i[3:0]` against the configured value's bits [3:0]. Bits [7:4] have no effect.
- R4: In mode 2'b10, `start_bit_i`=1 while sleeping sets the flag, and `rx_valid_i` alone does not.
- R5: In mode 2'b11, `rx_valid_i`=1 while sleeping sets the flag whatever the data, and `start_bit_i` alone does not.
- R6: In mode 2'b01, no input combination sets the flag.
- R7: A configuration write (`cfg_we_i`=1) updates `cfg_mode_o` on the next cycle when `port_en_i`=0. When `port_en_i`=1 the mode is left unchanged, while the other fields still load.
- R8: `wake_irq_o` is 1 exactly when the wakeup flag is set and the stored interrupt enable is 1.
- R9: With `sleep_i`=0, no event sets the flag.
- R10: Once set, the flag holds until a cycle with `wake_clr_i`=1. A clear in the same cycle as a qualifying event leaves the flag set.
- R11: A qualifying event sampled at a clock edge shows on `wake_flag_o` right after that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Mode to write: 00 match, 01 reserved, 10 start bit, 11 buffer non-empty |
| cfg_val_i | input | 8 | Match value to write |
| cfg_nib_i | input | 1 | Match width to write: 0 full byte, 1 low nibble |
| cfg_irq_en_i | input | 1 | Interrupt enable to write |
| port_en_i | input | 1 | Port enabled; locks the mode field |
| sleep_i | input | 1 | System is in the sleep state |
| start_bit_i | input | 1 | Start bit detected strobe |
| rx_valid_i | input | 1 | Receive buffer not empty strobe |
| rx_data_i | input | 8 | Received byte |
| wake_clr_i | input | 1 | Clear strobe for the wakeup flag |
| wake_flag_o | output | 1 | Sticky wakeup flag |
| wake_irq_o | output | 1 | Wakeup interrupt |
| cfg_mode_o | output | 2 | Stored mode field |

## Verification
The checker watches several rules on every cycle:

- the interrupt never rises without the flag;
- the mode holds across a write made while the port is enabled;
- a set flag holds without a clear;
- the reserved mode and the awake state never set the flag;
- start-bit and buffer events in their modes always set it on the next edge.

The byte compare needs the bench's sweeps to show its full behaviour. Those sweeps cover every received value against the stored value in both match widths, and every mode against every strobe pattern with and without sleep.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_MATCH = 2'b00,
    MODE_RSVD  = 2'b01,
    MODE_START = 2'b10,
    MODE_RXNE  = 2'b11
  } wake_mode_e;
endpackage

// File: rtl/swk_cfg_reg.sv
module swk_cfg_reg
  import swk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              port_en_i,
  input  wake_mode_e        mode_d_i,
  input  logic [DATA_W-1:0] val_d_i,
  input  logic              nib_d_i,
  input  logic              irq_en_d_i,
  output wake_mode_e        mode_q_o,
  output logic [DATA_W-1:0] val_q_o,
  output logic              nib_q_o,
  output logic              irq_en_q_o
);
  // mode field is locked while the port runs; other fields always load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= MODE_MATCH;
    end else if (we_i && !port_en_i) begin
      mode_q_o <= mode_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q_o    <= '0;
      nib_q_o    <= 1'b0;
      irq_en_q_o <= 1'b0;
    end else if (we_i) begin
      val_q_o    <= val_d_i;
      nib_q_o    <= nib_d_i;
      irq_en_q_o <= irq_en_d_i;
    end
  end
endmodule

// File: rtl/swk_match.sv
module swk_match #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOW_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              nib_i,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] LowMask = DATA_W'((1 << LOW_W) - 1);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] diff;

  assign mask  = nib_i ? LowMask : '1;
  assign diff  = (data_i ^ val_i) & mask;
  assign hit_o = (diff == '0);
endmodule

// File: rtl/swk_evt_flag.sv
module swk_evt_flag
  import swk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wake_mode_e mode_i,
  input  logic       sleep_i,
  input  logic       start_bit_i,
  input  logic       rx_valid_i,
  input  logic       hit_i,
  input  logic       clr_i,
  output logic       flag_o
);
  logic evt;

  always_comb begin
    unique case (mode_i)
      MODE_MATCH: evt = rx_valid_i && hit_i;
      MODE_START: evt = start_bit_i;
      MODE_RXNE:  evt = rx_valid_i;
      default:    evt = 1'b0;
    endcase
    evt = evt && sleep_i;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= evt || (flag_o && !clr_i);
  end
endmodule

// File: rtl/serial_wake_sel.sv
module serial_wake_sel
  import swk_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOW_W  = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [DATA_W-1:0] cfg_val_i,
  input  logic              cfg_nib_i,
  input  logic              cfg_irq_en_i,
  input  logic              port_en_i,
  input  logic              sleep_i,
  input  logic              start_bit_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              wake_clr_i,
  output logic              wake_flag_o,
  output logic              wake_irq_o,
  output logic [1:0]        cfg_mode_o
);
  wake_mode_e        mode_q;
  logic [DATA_W-1:0] val_q;
  logic              nib_q;
  logic              irq_en_q;
  logic              hit;

  swk_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .port_en_i  (port_en_i),
    .mode_d_i   (wake_mode_e'(cfg_mode_i)),
    .val_d_i    (cfg_val_i),
    .nib_d_i    (cfg_nib_i),
    .irq_en_d_i (cfg_irq_en_i),
    .mode_q_o   (mode_q),
    .val_q_o    (val_q),
    .nib_q_o    (nib_q),
    .irq_en_q_o (irq_en_q)
  );

  swk_match #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_match (
    .data_i (rx_data_i),
    .val_i  (val_q),
    .nib_i  (nib_q),
    .hit_o  (hit)
  );

  swk_evt_flag u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .sleep_i     (sleep_i),
    .start_bit_i (start_bit_i),
    .rx_valid_i  (rx_valid_i),
    .hit_i       (hit),
    .clr_i       (wake_clr_i),
    .flag_o      (wake_flag_o)
  );

  assign wake_irq_o = wake_flag_o && irq_en_q;
  assign cfg_mode_o = mode_q;
endmodule

// File: rtl/serial_wake_sel_chk.sv
module serial_wake_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic       port_en_i,
  input logic       sleep_i,
  input logic       start_bit_i,
  input logic       rx_valid_i,
  input logic       wake_clr_i,
  input logic       wake_flag_o,
  input logic       wake_irq_o,
  input logic [1:0] cfg_mode_o
);
  // R8: no interrupt without the flag
  a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> wake_flag_o);

  a_r7_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && port_en_i) |=> $stable(cfg_mode_o));

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_flag_o && !wake_clr_i) |=> wake_flag_o);

  a_r9_awake_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !wake_flag_o) |=> !wake_flag_o);

  a_r6_rsvd_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o == 2'b01 && !wake_flag_o) |=> !wake_flag_o);

  a_r4_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && cfg_mode_o == 2'b10 && start_bit_i) |=> wake_flag_o);

  a_r5_rxne_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && cfg_mode_o == 2'b11 && rx_valid_i) |=> wake_flag_o);
endmodule

bind serial_wake_sel serial_wake_sel_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .port_en_i   (port_en_i),
  .sleep_i     (sleep_i),
  .start_bit_i (start_bit_i),
  .rx_valid_i  (rx_valid_i),
  .wake_clr_i  (wake_clr_i),
  .wake_flag_o (wake_flag_o),
  .wake_irq_o  (wake_irq_o),
  .cfg_mode_o  (cfg_mode_o)
);

// File: tb/serial_wake_sel_tb.sv
module serial_wake_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] cfg_val = 8'h00;
  logic       cfg_nib = 1'b0;
  logic       cfg_irq_en = 1'b0;
  logic       port_en = 1'b0;
  logic       sleep = 1'b0;
  logic       start_bit = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       wake_clr = 1'b0;
  logic       wake_flag, wake_irq;
  logic [1:0] mode_rd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_wake_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_val_i(cfg_val), .cfg_nib_i(cfg_nib), .cfg_irq_en_i(cfg_irq_en),
    .port_en_i(port_en), .sleep_i(sleep), .start_bit_i(start_bit),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .wake_clr_i(wake_clr),
    .wake_flag_o(wake_flag), .wake_irq_o(wake_irq), .cfg_mode_o(mode_rd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic [7:0] v,
                           input logic nb, input logic ie, input logic pe);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_val = v; cfg_nib = nb;
    cfg_irq_en = ie; port_en = pe;
    @(negedge clk);
    cfg_we = 1'b0; port_en = 1'b0;
  endtask

  // drive one cycle of events, then sample after the edge
  task automatic step(input logic sl, input logic st, input logic rv,
                      input logic [7:0] d, input logic cl);
    @(negedge clk);
    sleep = sl; start_bit = st; rx_valid = rv; rx_data = d; wake_clr = cl;
    @(negedge clk);
    sleep = 1'b0; start_bit = 1'b0; rx_valid = 1'b0; wake_clr = 1'b0;
  endtask

  task automatic clear_flag();
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] mval;
    mval = 8'hA5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flag", int'(wake_flag), 0);
    chk("R1 irq", int'(wake_irq), 0);
    chk("R1 mode", int'(mode_rd), 0);
    rst_n = 1'b1;
    // R1: match value resets to 0, so mode 00 hits on data 0
    step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    chk("R1 val zero", int'(wake_flag), 1);
    chk("R1 irq_en zero", int'(wake_irq), 0);
    clear_flag();
    chk("R10 clear", int'(wake_flag), 0);

    // R2 / R3: sweep every byte in both compare widths
    for (int nb = 0; nb < 2; nb++) begin
      write_cfg(2'b00, mval, nb[0], 1'b0, 1'b0);
      for (int d = 0; d < 256; d++) begin
        int exp;
        exp = (nb == 0) ? int'(d[7:0] == mval) : int'(d[3:0] == mval[3:0]);
        step(1'b1, 1'b0, 1'b1, d[7:0], 1'b0);
        chk(nb == 0 ? "R2 full match" : "R3 nibble match", int'(wake_flag), exp);
        clear_flag();
      end
      // matching byte without rx_valid: no effect
      step(1'b1, 1'b1, 1'b0, mval, 1'b0);
      chk("R2 no strobe", int'(wake_flag), 0);
    end

    // R4/R5/R6/R9/R11: every mode x strobe pattern x sleep
    for (int m = 0; m < 4; m++) begin
      write_cfg(m[1:0], mval, 1'b0, 1'b0, 1'b0);
      chk("R7 mode write", int'(mode_rd), m);
      for (int pat = 0; pat < 4; pat++) begin
        for (int sl = 0; sl < 2; sl++) begin
          int exp;
          case (m)
            0: exp = pat[1];
            2: exp = pat[0];
            3: exp = pat[1];
            default: exp = 0;
          endcase
          if (sl == 0) exp = 0;
          step(sl[0], pat[0], pat[1], mval, 1'b0);
          if (sl == 0)      chk("R9 awake", int'(wake_flag), exp);
          else if (m == 1)  chk("R6 reserved", int'(wake_flag), exp);
          else if (m == 2)  chk("R4 start", int'(wake_flag), exp);
          else if (m == 3)  chk("R5 rxne", int'(wake_flag), exp);
          else              chk("R11 latency", int'(wake_flag), exp);
          clear_flag();
        end
      end
    end

    // R7 lock: write with port enabled is dropped for mode only
    write_cfg(2'b10, mval, 1'b0, 1'b0, 1'b0);
    write_cfg(2'b11, mval, 1'b0, 1'b1, 1'b1);
    chk("R7 locked", int'(mode_rd), 2);
    step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    chk("R7 locked behaviour", int'(wake_flag), 0);
    step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R8 irq on", int'(wake_irq), 1);

    // R10: hold without clear; clear and event together keeps set
    repeat (3) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R10 hold", int'(wake_flag), 1);
    clear_flag();
    chk("R8 irq off", int'(wake_irq), 0);
    step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
    chk("R10 set wins", int'(wake_flag), 1);
    write_cfg(2'b10, mval, 1'b0, 1'b0, 1'b0);
    chk("R8 irq disabled", int'(wake_irq), 0);
    chk("R8 flag kept", int'(wake_flag), 1);
    clear_flag();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule